// File: doc/BRIEF.md
# UART Receive DMA Request Controller

This block sits between a UART receiver and a DMA engine. Characters from the receiver enter a small FIFO. Each FIFO entry holds one data byte and four status bits. The controller packs these characters into 32-bit words and raises one DMA request at a time. Each request carries one to four bytes, and a byte-count field goes with it. For every byte delivered, the controller decrements a 16-bit count of bytes still owed to the current receive block.

The receiver can stop partway through a block, so the controller watches for a quiet line. Suppose the FIFO holds fewer than four characters, bytes are still owed, and 32 bit-times pass with no new character. The controller then enters padding. First it flushes any characters still held in the FIFO. After that it issues zero-valued dummy words until the count reaches zero.

During a block, the per-character status bits are ORed into a sticky value. When the block ends, that value and the number of genuine bytes are saved. A later request for a status fetch returns both in a single word instead of data.

Top module: `uart_rx_dma_ctl`

## Requirements
- R1: After reset, `dma_req` and `busy` are low, and `last_valid` and `last_status` are zero.
- R2: Bytes are packed little-endian: the k-th oldest character is placed in `dma_word[8k+7:8k]`. `dma_nbytes` holds the byte count minus one. Byte lanes above the count are zero.
- R3: Outside padding, a request is issued only once the FIFO holds min(4, remaining) characters, and it carries exactly that many.
- R4: A request stays asserted, with its word and byte count unchanged, until `dma_ack` is seen. Only one request is outstanding at a time.
- R5: `busy` rises in the cycle after an accepted start. Every request reduces the remaining count by its byte count. The block ends, and `busy` falls, once the count is zero and the last request has been acknowledged. No request is raised while idle.
- R6: A timeout occurs when all of these hold for 32 `bit_tick` pulses with no character arriving: the FIFO holds fewer than 4 characters and the remaining count is nonzero. After the timeout, the next request flushes min(held, 4, remaining) genuine bytes. Each request after that is an all-zero word of min(4, remaining) bytes.
- R7: `last_valid` is set at block end to the number of genuine bytes delivered. Dummy bytes are not counted.
- R8: Status bit encoding: bit0 = overrun, bit1 = parity, bit2 = framing, bit3 = break. The bits of the delivered characters are ORed into a sticky value. That value is cleared when a new data block starts and is copied to `last_status` at block end.
- R9: A start with `blk_fetch` high issues a single 4-byte request. Its word is {12'b0, `last_status`, `last_valid`}. It leaves `last_valid` and `last_status` unchanged.
- R10: The FIFO holds 16 characters. A character arriving while the FIFO is full is discarded, and the overrun bit of the newest stored character is set.
- R11: `blk_start` is ignored while `busy` is high.
- R12: A data block of length zero ends without any request, and `last_valid` becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One pulse per receive bit-time |
| chr_valid | input | 1 | A received character is presented |
| chr_data | input | 8 | Received character |
| chr_stat | input | 4 | Status bits of the character (R8 encoding) |
| blk_start | input | 1 | Start a block (single-cycle pulse) |
| blk_fetch | input | 1 | With `blk_start`, return previous-block status instead of data |
| blk_len | input | 16 | Byte length of the data block |
| busy | output | 1 | A block or status fetch is in progress |
| dma_req | output | 1 | DMA request |
| dma_word | output | 32 | Packed data word of the request |
| dma_nbytes | output | 2 | Bytes in the request minus one |
| dma_ack | input | 1 | DMA acknowledge of the current request |
| last_valid | output | 16 | Genuine bytes in the previous block |
| last_status | output | 4 | Sticky status of the previous block |

## Verification
The bench covers these corner cases:
- **Short tails.** A final partial word must carry only its own bytes. A packer that ignores the remaining count would fetch too much, or leave junk in the upper byte lanes.
- **Timeout with data still held.** A design that padded at once would drop those bytes from the data and from the valid count.
- **Timeout with an empty FIFO.** A wrong design would either hang or count the dummy bytes as valid.
- **FIFO overflow while idle.** A careless FIFO would overwrite the oldest entry or deliver the seventeenth character, and the overrun flag would never reach the status.
- **A start pulse arriving mid-block.** A wrong design would reload the byte count and stall the block.
- **A zero-length block.** A wrong design would request data for it.
- **A status fetch after each kind of block.** This shows whether the sticky status was cleared and whether the saved count survived the fetch.

// File: rtl/uart_rx_dma_pkg.sv
package uart_rx_dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_STAT = 2'd2
   } rxdma_state_e;

   localparam int STAT_W   = 4;
   localparam int STAT_OVR = 0;
   localparam int STAT_PAR = 1;
   localparam int STAT_FRM = 2;
   localparam int STAT_BRK = 3;
endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo
   import uart_rx_dma_pkg::*;
#(
   parameter  int DEPTH  = 16,
   parameter  int DATA_W = 8,
   parameter  int TAPS   = 4,
   localparam int AW     = $clog2(DEPTH),
   localparam int NW     = $clog2(TAPS + 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              push_i,
   input  logic [DATA_W-1:0]                 push_data_i,
   input  logic [STAT_W-1:0]                 push_stat_i,
   input  logic [NW-1:0]                     pop_n_i,
   output logic [TAPS-1:0][DATA_W-1:0]       tap_data_o,
   output logic [TAPS-1:0][STAT_W-1:0]       tap_stat_o,
   output logic [AW:0]                       count_o
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2 * TAPS) begin : g_bad_depth
      $error("rxdma_fifo: DEPTH must be a power of two and at least twice TAPS");
   end

   logic [DATA_W-1:0] mem_d [DEPTH];
   logic [STAT_W-1:0] mem_s [DEPTH];
   logic [AW-1:0]     rd_ptr, wr_ptr;
   logic [AW:0]       count;
   logic              full, accept;

   assign full    = (count == (AW+1)'(DEPTH));
   assign accept  = push_i && !full;
   assign count_o = count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         rd_ptr <= rd_ptr + AW'(pop_n_i);
         if (accept) wr_ptr <= wr_ptr + AW'(1);
         count  <= count + (AW+1)'(accept) - (AW+1)'(pop_n_i);
      end
   end

   // a full FIFO drops the newcomer and flags the newest stored entry
   always_ff @(posedge clk) begin
      if (accept) begin
         mem_d[wr_ptr] <= push_data_i;
         mem_s[wr_ptr] <= push_stat_i;
      end else if (push_i) begin
         mem_s[wr_ptr - AW'(1)][STAT_OVR] <= 1'b1;
      end
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign tap_data_o[k] = mem_d[rd_ptr + AW'(k)];
      assign tap_stat_o[k] = mem_s[rd_ptr + AW'(k)];
   end

   assert_pop_le_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (AW+1)'(pop_n_i) <= count);
   assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/rxdma_timeout.sv
module rxdma_timeout #(
   parameter  int TMO_BITS = 32,
   localparam int TW       = $clog2(TMO_BITS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic restart_i,
   input  logic bit_tick_i,
   output logic fire_o
);
   if (TMO_BITS < 1) begin : g_bad_tmo
      $error("rxdma_timeout: TMO_BITS must be positive");
   end

   logic [TW-1:0] ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ticks <= '0;
      else if (!arm_i || restart_i)               ticks <= '0;
      else if (bit_tick_i && ticks != TW'(TMO_BITS)) ticks <= ticks + TW'(1);
   end

   assign fire_o = arm_i && !restart_i && (ticks == TW'(TMO_BITS));

   assert_fire_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> arm_i);
endmodule

// File: rtl/uart_rx_dma_ctl.sv
module uart_rx_dma_ctl
   import uart_rx_dma_pkg::*;
#(
   parameter  int DEPTH    = 16,
   parameter  int CNT_W    = 16,
   parameter  int TMO_BITS = 32,
   parameter  int TAPS     = 4,
   localparam int WORD_W   = 8 * TAPS,
   localparam int AW       = $clog2(DEPTH),
   localparam int NW       = $clog2(TAPS + 1),
   localparam int BW       = $clog2(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              chr_valid,
   input  logic [7:0]        chr_data,
   input  logic [3:0]        chr_stat,
   input  logic              blk_start,
   input  logic              blk_fetch,
   input  logic [CNT_W-1:0]  blk_len,
   output logic              busy,
   output logic              dma_req,
   output logic [WORD_W-1:0] dma_word,
   output logic [BW-1:0]     dma_nbytes,
   input  logic              dma_ack,
   output logic [CNT_W-1:0]  last_valid,
   output logic [3:0]        last_status
);
   if (CNT_W + STAT_W > WORD_W) begin : g_bad_word
      $error("uart_rx_dma_ctl: status word does not fit in one DMA word");
   end

   rxdma_state_e              state;
   logic [CNT_W-1:0]          rem, vcnt;
   logic [STAT_W-1:0]         sticky;
   logic                      pad;
   logic [TAPS-1:0][7:0]      tap_d;
   logic [TAPS-1:0][3:0]      tap_s;
   logic [AW:0]               fcnt;
   logic [NW-1:0]             lim, have, n_take, pop_n;
   logic                      issue, real_data, arm, fire;
   logic [WORD_W-1:0]         word_nx;
   logic [STAT_W-1:0]         stat_or;
   logic [TAPS-1:0][3:0]      stat_sel;

   rxdma_fifo #(.DEPTH(DEPTH), .DATA_W(8), .TAPS(TAPS)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(chr_valid), .push_data_i(chr_data),
      .push_stat_i(chr_stat), .pop_n_i(pop_n), .tap_data_o(tap_d),
      .tap_stat_o(tap_s), .count_o(fcnt));

   assign arm = (state == ST_DATA) && !pad && (rem != '0) && (fcnt < (AW+1)'(TAPS));

   rxdma_timeout #(.TMO_BITS(TMO_BITS)) u_tmo (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .restart_i(chr_valid),
      .bit_tick_i(bit_tick), .fire_o(fire));

   // request sizing
   assign lim       = (rem >= CNT_W'(TAPS)) ? NW'(TAPS) : NW'(rem);
   assign have      = (fcnt >= (AW+1)'(lim)) ? lim : NW'(fcnt);
   assign real_data = !(pad && fcnt == '0);
   assign n_take    = real_data ? have : lim;
   assign issue     = (state == ST_DATA) && !dma_req && (rem != '0) &&
                      (pad || fcnt >= (AW+1)'(lim));
   assign pop_n     = (issue && real_data) ? n_take : '0;

   for (genvar k = 0; k < TAPS; k++) begin : g_pack
      logic sel;
      assign sel              = real_data && (NW'(k) < n_take);
      assign word_nx[8*k +: 8] = sel ? tap_d[k] : 8'h00;
      assign stat_sel[k]      = sel ? tap_s[k] : 4'h0;
   end

   always_comb begin
      stat_or = '0;
      for (int k = 0; k < TAPS; k++) stat_or |= stat_sel[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         rem         <= '0;
         vcnt        <= '0;
         sticky      <= '0;
         pad         <= 1'b0;
         dma_req     <= 1'b0;
         dma_word    <= '0;
         dma_nbytes  <= '0;
         last_valid  <= '0;
         last_status <= '0;
      end else begin
         case (state)
            ST_IDLE: if (blk_start) begin
               if (blk_fetch) begin
                  dma_req    <= 1'b1;
                  dma_word   <= WORD_W'({last_status, last_valid});
                  dma_nbytes <= BW'(TAPS - 1);
                  state      <= ST_STAT;
               end else begin
                  rem    <= blk_len;
                  vcnt   <= '0;
                  sticky <= '0;
                  pad    <= 1'b0;
                  state  <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (fire) pad <= 1'b1;
               if (dma_req && dma_ack) dma_req <= 1'b0;
               if (issue) begin
                  dma_req    <= 1'b1;
                  dma_word   <= word_nx;
                  dma_nbytes <= BW'(n_take - NW'(1));
                  rem        <= rem - CNT_W'(n_take);
                  if (real_data) vcnt <= vcnt + CNT_W'(n_take);
                  sticky     <= sticky | stat_or;
               end else if (!dma_req && rem == '0) begin
                  last_valid  <= vcnt;
                  last_status <= sticky;
                  state       <= ST_IDLE;
               end
            end
            ST_STAT: if (dma_ack) begin
               dma_req <= 1'b0;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !dma_ack |=> dma_req && $stable(dma_word) && $stable(dma_nbytes));
   assert_idle_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !dma_req);
   assert_upper_lanes_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> ((dma_word >> (8 * (32'(dma_nbytes) + 1))) == '0));
   assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy && blk_start && state == ST_DATA |=> $stable(last_valid));
endmodule

// File: tb/tb_uart_rx_dma_ctl.sv
module tb_uart_rx_dma_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_tick = 1'b0;
   logic        chr_valid = 1'b0;
   logic [7:0]  chr_data = '0;
   logic [3:0]  chr_stat = '0;
   logic        blk_start = 1'b0;
   logic        blk_fetch = 1'b0;
   logic [15:0] blk_len = '0;
   logic        busy, dma_req;
   logic [31:0] dma_word;
   logic [1:0]  dma_nbytes;
   logic        dma_ack = 1'b0;
   logic [15:0] last_valid;
   logic [3:0]  last_status;

   always #4 clk = ~clk;

   uart_rx_dma_ctl dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .chr_valid(chr_valid),
      .chr_data(chr_data), .chr_stat(chr_stat), .blk_start(blk_start),
      .blk_fetch(blk_fetch), .blk_len(blk_len), .busy(busy), .dma_req(dma_req),
      .dma_word(dma_word), .dma_nbytes(dma_nbytes), .dma_ack(dma_ack),
      .last_valid(last_valid), .last_status(last_status));

   int checks = 0, errors = 0, ack_delay = 0, held = 0, cyc = 0, tdiv = 0;
   logic [31:0] exp_word[$];
   logic [1:0]  exp_nb[$];
   string       exp_tag[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic expect_word(input string tag, input logic [31:0] w, input logic [1:0] nb);
      exp_word.push_back(w);
      exp_nb.push_back(nb);
      exp_tag.push_back(tag);
   endtask

   // bit-time strobe: one pulse every 4 clocks
   always @(negedge clk) begin
      tdiv++;
      bit_tick = (tdiv % 4 == 0);
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (dma_ack) dma_ack = 1'b0;
      else if (dma_req) begin
         if (exp_word.size() == 0) begin
            chk(1'b0, "R5", "unexpected request", dma_word, 32'h0);
            dma_ack = 1'b1;
         end else if (held < ack_delay) begin
            chk(dma_word == exp_word[0] && dma_nbytes == exp_nb[0], "R4",
                "held request changed", dma_word, exp_word[0]);
            held++;
         end else begin
            chk(dma_word == exp_word[0], exp_tag[0], "word", dma_word, exp_word[0]);
            chk(dma_nbytes == exp_nb[0], exp_tag[0], "nbytes", 32'(dma_nbytes), 32'(exp_nb[0]));
            void'(exp_word.pop_front());
            void'(exp_nb.pop_front());
            void'(exp_tag.pop_front());
            held = 0;
            dma_ack = 1'b1;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic send(input logic [7:0] d, input logic [3:0] s);
      chr_valid = 1'b1; chr_data = d; chr_stat = s;
      @(negedge clk);
      chr_valid = 1'b0; chr_stat = '0;
   endtask

   task automatic start(input logic [15:0] len, input logic fetch);
      blk_start = 1'b1; blk_len = len; blk_fetch = fetch;
      @(negedge clk);
      blk_start = 1'b0; blk_fetch = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while ((busy || exp_word.size() != 0) && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(n < 3000, tag, "block did not complete", 32'(n), 32'd3000);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!dma_req && !busy, "R1", "outputs during reset", {dma_req, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(last_valid == 0 && last_status == 0, "R1", "saved status after reset",
          {last_status, last_valid}, 0);

      // R2/R3: six bytes -> full word then two-byte tail
      expect_word("R2", 32'ha3a2a1a0, 2'd3);
      expect_word("R3", 32'h0000a5a4, 2'd1);
      start(16'd6, 1'b0);
      chk(busy, "R5", "busy after start", busy, 1);
      for (int i = 0; i < 6; i++) send(8'ha0 + 8'(i), 4'h0);
      wait_done("R5");
      chk(!busy, "R5", "busy after block", busy, 0);
      chk(last_valid == 16'd6, "R7", "valid count", last_valid, 6);
      chk(last_status == 4'h0, "R8", "clean status", last_status, 0);

      // R9: status fetch
      expect_word("R9", 32'h0000_0006, 2'd3);
      start(16'd0, 1'b1);
      wait_done("R9");
      chk(last_valid == 16'd6, "R9", "fetch kept count", last_valid, 6);

      // R6: timeout with one char held, parity error on one char
      expect_word("R6", 32'hc3c2c1c0, 2'd3);
      expect_word("R6", 32'h000000c4, 2'd0);
      expect_word("R6", 32'h00000000, 2'd2);
      start(16'd8, 1'b0);
      for (int i = 0; i < 5; i++) send(8'hc0 + 8'(i), (i == 2) ? 4'b0010 : 4'b0000);
      wait_done("R6");
      chk(last_valid == 16'd5, "R7", "dummy bytes not counted", last_valid, 5);
      chk(last_status == 4'b0010, "R8", "parity sticky", last_status, 4'b0010);
      expect_word("R8", 32'h0002_0005, 2'd3);
      start(16'd0, 1'b1);
      wait_done("R8");

      // R12: zero-length block
      start(16'd0, 1'b0);
      wait_done("R12");
      chk(last_valid == 0 && last_status == 0, "R12", "zero block status",
          {last_status, last_valid}, 0);

      // R6: timeout with empty FIFO
      expect_word("R6", 32'h00000000, 2'd3);
      start(16'd4, 1'b0);
      wait_done("R6");
      chk(last_valid == 0, "R7", "all-dummy block count", last_valid, 0);

      // R11: start during a busy block is ignored
      expect_word("R11", 32'h13121110, 2'd3);
      start(16'd4, 1'b0);
      send(8'h10, 4'h0);
      send(8'h11, 4'h0);
      start(16'd9, 1'b0);
      send(8'h12, 4'h0);
      send(8'h13, 4'h0);
      wait_done("R11");
      chk(last_valid == 16'd4, "R11", "length not reloaded", last_valid, 4);

      // R10: overflow while idle, with held acknowledges (R4)
      ack_delay = 3;
      for (int i = 0; i < 17; i++) send(8'h40 + 8'(i), 4'h0);
      for (int w = 0; w < 4; w++)
         expect_word("R10", {8'h43 + 8'(4*w), 8'h42 + 8'(4*w), 8'h41 + 8'(4*w), 8'h40 + 8'(4*w)}, 2'd3);
      start(16'd16, 1'b0);
      wait_done("R10");
      chk(last_status == 4'b0001, "R10", "overrun flagged", last_status, 4'b0001);
      chk(last_valid == 16'd16, "R10", "full block count", last_valid, 16);
      ack_delay = 0;
      expect_word("R10", 32'h00000099, 2'd0);
      start(16'd1, 1'b0);
      send(8'h99, 4'h0);
      wait_done("R10");

      chk(exp_word.size() == 0, "R5", "leftover expected words", 32'(exp_word.size()), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule